// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block turns bytes held in an external transmit queue into asynchronous serial characters on a single output pin. A 16-bit phase accumulator is advanced by a programmable increment on every clock. Its carry-out is a tick at sixteen times the baud rate, and every serial bit lasts exactly sixteen of these ticks. A character is a low start bit, then eight data bits sent least significant first, then an optional parity bit (even or odd, computed over the data), then a high stop bit. The line rests high between characters.

When flow control is on, the active-low clear-to-send input is synchronized and checked only at the point where a new character would begin. A high level holds the next character back. Once a character is under way, that input is ignored until its stop bit is complete. A byte is taken from the queue in the same cycle as its start bit begins. If the queue still holds data at the end of a stop bit, the next start bit follows with no idle gap.

Two paths bypass the serializer at the pin. The override forces a fixed level onto the pin. The line-loopback path copies the synchronized receive input onto the pin. The override has priority over loopback.

Top module: `uart_tx_line`

## Requirements
- R1: After reset, and whenever no character is in progress and neither bypass is enabled, `tx` is 1, `busy` is 0 and `fifo_pop` is 0.
- R2: A character is sent as a 0 start bit, then `fifo_data[0]` through `fifo_data[7]` in that order, then a 1 stop bit.
- R3: With `parity_en`=1, one parity bit goes between bit 7 and the stop bit. Its value is the XOR of the 8 data bits when `parity_odd`=0, and the inverse of that XOR when `parity_odd`=1. With `parity_en`=0, no parity bit is sent.
- R4: The tick is the carry-out of a 16-bit accumulator that adds `nco_inc` on every clock. An increment of 16'h8000 gives one tick every 2 clocks.
- R5: When the queue is non-empty at the end of a stop bit, the next start bit begins in the very next bit period.
- R6: With `flow_en`=1 and `cts_n`=1, no character starts, no pop occurs and `tx` stays 1. Once `cts_n` goes to 0, the waiting character is sent.
- R7: Once a character has started, a change on `cts_n` does not alter or stop that character.
- R8: With `ovrd_en`=1, `tx` equals `ovrd_val`.
- R9: With `lpbk_en`=1 and `ovrd_en`=0, `tx` follows `rx_in` two clocks late, through a two-stage synchronizer.
- R10: Every bit lasts 16 ticks. `busy` is 1 from the start bit through the end of the stop bit: 160 ticks without parity and 176 ticks with parity.
- R11: `fifo_pop` pulses for exactly one clock per character, at the moment that character's start bit begins, and never when `fifo_empty`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nco_inc | input | 16 | Accumulator increment per clock |
| parity_en | input | 1 | Insert a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| flow_en | input | 1 | Gate character starts on clear-to-send |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| fifo_empty | input | 1 | Transmit queue holds no byte |
| fifo_data | input | 8 | Byte at the head of the queue |
| fifo_pop | output | 1 | Remove the head byte from the queue |
| rx_in | input | 1 | Receive pin, asynchronous, used by loopback |
| lpbk_en | input | 1 | Copy the synchronized receive pin onto tx |
| ovrd_en | input | 1 | Force tx to ovrd_val |
| ovrd_val | input | 1 | Forced tx level |
| tx | output | 1 | Serial output pin |
| busy | output | 1 | A character is in progress |

## Verification
The bench measures the duration of `busy` in clocks, so a bit period of 15 or 17 ticks, or a missing or extra parity slot, changes the count it sees. It samples the line one bit period after a stop bit and expects a start bit there. A design that returned to idle for one period before the next character would show a high line at that point. It holds `cts_n` high with data waiting and checks that no pop and no start occur. It then raises `cts_n` in the middle of a character, where a design that aborted or stalled would corrupt the frame or stretch `busy`. Odd and even parity are checked on bytes with both even and odd numbers of ones, and the override is checked against active loopback to confirm the priority.

// File: rtl/uart_tx_line.sv
module uart_tx_line #(
  parameter int ACC_W  = 16,
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  nco_inc,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              flow_en,
  input  logic              cts_n,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  input  logic              rx_in,
  input  logic              lpbk_en,
  input  logic              ovrd_en,
  input  logic              ovrd_val,
  output logic              tx,
  output logic              busy
);
  localparam int SUB_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t               st;
  logic [ACC_W-1:0]  acc;
  logic              tick;
  logic [SUB_W-1:0]  sub;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic              par_q;
  logic [1:0]        cts_sync, rx_sync;
  logic              bit_end, may_start, go, line;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) acc <= '0;
    else        acc <= acc + nco_inc;

  assign tick = ({1'b0, acc} + {1'b0, nco_inc}) > {1'b0, {ACC_W{1'b1}}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cts_sync <= 2'b11;
      rx_sync  <= 2'b11;
    end else begin
      cts_sync <= {cts_sync[0], cts_n};
      rx_sync  <= {rx_sync[0], rx_in};
    end

  assign bit_end   = tick && (sub == SUB_LAST);
  assign may_start = (st == S_IDLE && tick) || (st == S_STOP && bit_end);
  assign go        = may_start && !fifo_empty && !(flow_en && cts_sync[1]);
  assign fifo_pop  = go;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st    <= S_IDLE;
      sub   <= '0;
      bitn  <= '0;
      shreg <= '0;
      par_q <= 1'b0;
    end else if (go) begin
      st    <= S_START;
      sub   <= '0;
      bitn  <= '0;
      shreg <= fifo_data;
      par_q <= (^fifo_data) ^ parity_odd;
    end else if (tick && st != S_IDLE) begin
      sub <= sub + 1'b1;
      if (sub == SUB_LAST) begin
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            shreg <= shreg >> 1;
            bitn  <= bitn + 1'b1;
            if (bitn == BIT_LAST) st <= parity_en ? S_PAR : S_STOP;
          end
          S_PAR:   st <= S_STOP;
          default: st <= S_IDLE;
        endcase
      end
    end

  always_comb
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = shreg[0];
      S_PAR:   line = par_q;
      default: line = 1'b1;
    endcase

  assign busy = (st != S_IDLE);
  assign tx   = ovrd_en ? ovrd_val : (lpbk_en ? rx_sync[1] : line);

  a_r11_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  a_r11_pop_begins_start: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> (st == S_START && sub == '0));
  a_r6_cts_gates_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && flow_en) |-> !cts_sync[1]);
  a_r10_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sub != $past(sub)) |-> $past(tick));
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ovrd_en && !lpbk_en) |-> tx);
  a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(st == S_STOP && bit_end)) |=> busy);
endmodule

// File: tb/uart_tx_line_bench.sv
module uart_tx_line_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [15:0] nco_inc = 16'h8000;
  logic parity_en = 0, parity_odd = 0, flow_en = 0, cts_n = 1;
  logic rx_in = 1, lpbk_en = 0, ovrd_en = 0, ovrd_val = 0;
  logic fifo_empty, fifo_pop, tx, busy;
  logic [7:0] fifo_data;

  logic [7:0] qmem [16];
  logic [3:0] wr = 0, rd = 0;
  int pops = 0;
  assign fifo_empty = (wr == rd);
  assign fifo_data  = qmem[rd];
  always @(posedge clk) if (fifo_pop) begin rd <= rd + 1'b1; pops <= pops + 1; end

  uart_tx_line u_uart_tx_line (
    .clk(clk), .rst_n(rst_n), .nco_inc(nco_inc), .parity_en(parity_en),
    .parity_odd(parity_odd), .flow_en(flow_en), .cts_n(cts_n),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .rx_in(rx_in), .lpbk_en(lpbk_en), .ovrd_en(ovrd_en), .ovrd_val(ovrd_val),
    .tx(tx), .busy(busy));

  int tests = 0, fails = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    qmem[wr] = b;
    wr = wr + 1'b1;
  endtask

  task automatic wait_start;
    int n = 0;
    while (tx !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
  endtask

  // Receive one frame; at_mid=1 means already at the middle of the start bit.
  task automatic rx_frame(input bit at_mid, input string req,
                          input logic [7:0] data, input logic pe, input logic po);
    logic [7:0] got;
    logic p, s;
    if (!at_mid) begin wait_start(); repeat (16) @(negedge clk); end
    chk({req, " start bit"}, {15'd0, tx}, 16'd0);
    for (int i = 0; i < 8; i++) begin repeat (32) @(negedge clk); got[i] = tx; end
    chk({req, " data"}, {8'd0, got}, {8'd0, data});
    if (pe) begin
      repeat (32) @(negedge clk); p = tx;
      chk({req, " R3 parity"}, {15'd0, p}, {15'd0, (^data) ^ po});
    end
    repeat (32) @(negedge clk); s = tx;
    chk({req, " stop bit"}, {15'd0, s}, 16'd1);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!busy && n < 5000) @(negedge clk);
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
  endtask

  // {parity_en, parity_odd, data}
  localparam logic [9:0] VEC [6] = '{
    {2'b00, 8'hA5}, {2'b00, 8'h01}, {2'b10, 8'h03},
    {2'b10, 8'h07}, {2'b11, 8'h0F}, {2'b11, 8'h80}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset tx", {15'd0, tx}, 16'd1);
    chk("R1 reset busy", {15'd0, busy}, 16'd0);
    chk("R1 reset pop", {15'd0, fifo_pop}, 16'd0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 idle tx", {15'd0, tx}, 16'd1);

    foreach (VEC[k]) begin
      parity_en = VEC[k][9]; parity_odd = VEC[k][8];
      push(VEC[k][7:0]);
      rx_frame(0, "R2", VEC[k][7:0], VEC[k][9], VEC[k][8]);
      repeat (40) @(negedge clk);
    end

    parity_en = 0;
    push(8'h3C);
    busy_len(n);
    chk("R10 R4 busy length no parity", 16'(n), 16'd320);
    parity_en = 1;
    push(8'h3C);
    busy_len(n);
    chk("R10 busy length parity", 16'(n), 16'd352);
    parity_en = 0;

    push(8'h55); push(8'hC3);
    rx_frame(0, "R5 first", 8'h55, 0, 0);
    repeat (32) @(negedge clk);
    chk("R5 back to back start", {15'd0, tx}, 16'd0);
    rx_frame(1, "R5 second", 8'hC3, 0, 0);
    repeat (40) @(negedge clk);

    flow_en = 1; cts_n = 1;
    n = pops;
    push(8'h96);
    repeat (2000) @(negedge clk);
    chk("R6 held tx", {15'd0, tx}, 16'd1);
    chk("R6 held busy", {15'd0, busy}, 16'd0);
    chk("R6 held pops", 16'(pops - n), 16'd0);
    cts_n = 0;
    rx_frame(0, "R6 released", 8'h96, 0, 0);
    repeat (40) @(negedge clk);

    push(8'h69);
    wait_start();
    cts_n = 1;
    repeat (16) @(negedge clk);
    rx_frame(1, "R7 cts dropped mid", 8'h69, 0, 0);
    repeat (40) @(negedge clk);
    chk("R7 idle afterwards", {15'd0, busy}, 16'd0);
    flow_en = 0; cts_n = 0;
    repeat (40) @(negedge clk);

    n = pops;
    push(8'h11); push(8'h22); push(8'h33);
    repeat (1200) @(negedge clk);
    chk("R11 one pop per character", 16'(pops - n), 16'd3);

    lpbk_en = 1; rx_in = 0;
    repeat (3) @(negedge clk);
    chk("R9 loopback low", {15'd0, tx}, 16'd0);
    rx_in = 1;
    @(negedge clk);
    chk("R9 loopback sync delay", {15'd0, tx}, 16'd0);
    repeat (2) @(negedge clk);
    chk("R9 loopback high", {15'd0, tx}, 16'd1);
    rx_in = 0;
    repeat (3) @(negedge clk);
    ovrd_en = 1; ovrd_val = 1;
    #1;
    chk("R8 override beats loopback", {15'd0, tx}, 16'd1);
    lpbk_en = 0; ovrd_val = 0;
    #1;
    chk("R8 override low", {15'd0, tx}, 16'd0);
    ovrd_en = 0;
    #1;
    chk("R1 after bypass", {15'd0, tx}, 16'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule